// File: doc/BRIEF.md
# Partitioned Minimum-Capacity Configuration Bank

This block keeps, for every partition ID, a minimum cache-capacity fraction: the share of a cache that the partition has priority to allocate. Software never addresses an entry directly. It first writes a select register (offset 0x100) with a partition ID, an optional resource-instance index and an internal flag. It then reads or writes a data window (offset 0x110) that maps onto the entry those fields point at. The cache allocation logic that consumes the fractions sits outside this block.

There are four fully separate banks, one per security space: 0 secure, 1 non-secure, 2 root, 3 realm. The 2-bit space tag of each request picks the bank. Each bank has its own select register and its own fraction storage. Nothing in one bank can reach another bank's entries.

The fraction is an unsigned 16-bit fixed-point value with the binary point above bit 15, so it is always below 1. Only its top `FRAC_W` bits are stored. Its largest value is therefore 1 - 2^-FRAC_W.

The request side is a valid/ready channel. `req_ready` is held high, so there is never any back-pressure, and a request is accepted on every clock edge where `req_valid` is high. Each accepted read returns exactly one response, with `rsp_valid` high for one cycle on the edge after acceptance. The response channel has no ready and cannot be stalled. Writes produce no response.

Top module: `capl_bank_top`

## Requirements
- R1: After reset, every select register and every stored fraction in every bank reads as zero, and `req_ready` is 1.
- R2: An accepted read sets `rsp_valid` for exactly one cycle, on the edge after acceptance. Writes and idle cycles leave `rsp_valid` low.
- R3: A window read returns the selected fraction in bits [15:0] and zero in bits [31:16]. Writes to bits [31:16] are discarded.
- R4: Only the top `FRAC_W` bits of the 16-bit fraction (bits [15:16-FRAC_W]) are stored. The lower bits read as zero and ignore writes.
- R5: The select register holds the partition ID in bits [PID_W-1:0], the internal flag in bit 16 and, when `RIS_EN` is 1, the resource index in bits [24+RIS_W-1:24]. All other bits read as zero. A select write applies to the very next window access, with no stall cycle.
- R6: The four banks are independent. A select or window write in one space changes no value read in any other space.
- R7: With `RIS_EN`=1, the entry index is {resource index, partition ID}. With `RIS_EN`=0, the entry index is the partition ID alone, and resource-index bits are neither stored nor used.
- R8: A window access is valid only when the internal flag equals `NARROW_EN`. Otherwise it reads zero and the write is discarded.
- R9: A window access whose partition ID exceeds `PID_MAX`, or (with `RIS_EN`=1) whose resource index exceeds `RIS_MAX`, reads zero and the write is discarded.
- R10: With `REALM_EN`=0, every access in the root or realm space reads zero and every write there is discarded, the select register included.
- R11: With `FEAT_EN`=0, every window read returns zero and every window write is discarded.
- R12: Reads of any offset other than 0x100 and 0x110 return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (held high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | Security space: 0 secure, 1 non-secure, 2 root, 3 realm |
| req_addr | input | ADDR_W | Byte offset within the bank frame |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench builds three instances on one shared request bus:
- **Instance 1** uses the default parameters: 12 partitions, 3 resource instances, 8-bit fraction, narrowing off, root and realm enabled, feature present. It reaches the combined {resource, partition} index, the partition and resource limits, and all four live banks.
- **Instance 2** has resource instances off, a 5-bit fraction, narrowing on and root/realm disabled. It brings within reach index aliasing across resource-index values, the inverted internal-flag rule, and space gating.
- **Instance 3** has the feature absent, which exercises window gating while its select registers stay live.

// File: rtl/capl_pkg.sv
package capl_pkg;
  typedef enum logic [1:0] {
    SP_SECURE    = 2'd0,
    SP_NONSECURE = 2'd1,
    SP_ROOT      = 2'd2,
    SP_REALM     = 2'd3
  } space_e;

  localparam int NUM_SPACES   = 4;
  localparam int FRAC_FIELD_W = 16;
  localparam int SEL_INT_BIT  = 16;
  localparam int SEL_RIS_LSB  = 24;
  localparam logic [11:0] OFS_SELECT = 12'h100;
  localparam logic [11:0] OFS_WINDOW = 12'h110;
endpackage

// File: rtl/capl_sel_reg.sv
module capl_sel_reg #(
  parameter int PID_W  = 4,
  parameter int RIS_W  = 2,
  parameter bit RIS_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  output logic [PID_W-1:0] pid,
  output logic [RIS_W-1:0] ris,
  output logic             internal,
  output logic [31:0]      rd_word
);
  import capl_pkg::*;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid      <= '0;
      internal <= 1'b0;
    end else if (wr_en) begin
      pid      <= wdata[PID_W-1:0];
      internal <= wdata[SEL_INT_BIT];
    end
  end

  generate
    if (RIS_EN) begin : g_ris
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ris <= '0;
        else if (wr_en) ris <= wdata[SEL_RIS_LSB +: RIS_W];
      end
    end else begin : g_no_ris
      assign ris = '0;
    end
  endgenerate

  always_comb begin
    rd_word                    = '0;
    rd_word[PID_W-1:0]         = pid;
    rd_word[SEL_INT_BIT]       = internal;
    rd_word[SEL_RIS_LSB +: RIS_W] = ris;
  end
endmodule

// File: rtl/capl_entry_decode.sv
module capl_entry_decode #(
  parameter int PID_W     = 4,
  parameter int RIS_W     = 2,
  parameter bit RIS_EN    = 1'b1,
  parameter int PID_MAX   = 11,
  parameter int RIS_MAX   = 2,
  parameter bit NARROW_EN = 1'b0,
  parameter int IDX_W     = RIS_EN ? (RIS_W + PID_W) : PID_W
) (
  input  logic [PID_W-1:0] pid,
  input  logic [RIS_W-1:0] ris,
  input  logic             internal,
  output logic [IDX_W-1:0] idx,
  output logic             hit
);
  logic ris_ok;
  logic pid_ok;

  generate
    if (RIS_EN) begin : g_ris_idx
      assign idx    = {ris, pid};
      assign ris_ok = (ris <= RIS_W'(RIS_MAX));
    end else begin : g_pid_idx
      logic unused_ris;
      assign unused_ris = ^ris;
      assign idx    = pid;
      assign ris_ok = 1'b1;
    end
  endgenerate

  assign pid_ok = (pid <= PID_W'(PID_MAX));
  assign hit    = (internal == NARROW_EN) && pid_ok && ris_ok;
endmodule

// File: rtl/capl_frac_store.sv
module capl_frac_store #(
  parameter int IDX_W  = 6,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [FRAC_W-1:0] wr_frac,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [FRAC_W-1:0] rd_frac
);
  localparam int DEPTH = 1 << IDX_W;

  logic [FRAC_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_frac;
    end
  end

  assign rd_frac = mem[rd_idx];
endmodule

// File: rtl/capl_bank_top.sv
module capl_bank_top #(
  parameter int ADDR_W    = 12,
  parameter int PID_W     = 4,
  parameter int PID_MAX   = 11,
  parameter bit RIS_EN    = 1'b1,
  parameter int RIS_W     = 2,
  parameter int RIS_MAX   = 2,
  parameter int FRAC_W    = 8,
  parameter bit NARROW_EN = 1'b0,
  parameter bit REALM_EN  = 1'b1,
  parameter bit FEAT_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  import capl_pkg::*;

  localparam int IDX_W   = RIS_EN ? (RIS_W + PID_W) : PID_W;
  localparam int LOW_PAD = FRAC_FIELD_W - FRAC_W;
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFS_SELECT);
  localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(OFS_WINDOW);

  logic        space_ok;
  logic        sel_hit;
  logic        win_hit;
  logic        rd_accept;
  logic [31:0] rd_mux;
  logic [31:0] sel_word  [NUM_SPACES];
  logic [31:0] frac_word [NUM_SPACES];

  assign req_ready = 1'b1;
  assign space_ok  = (req_space == SP_SECURE) || (req_space == SP_NONSECURE) || REALM_EN;
  assign sel_hit   = req_valid && space_ok && (req_addr == A_SEL);
  assign win_hit   = req_valid && space_ok && (req_addr == A_WIN) && FEAT_EN;
  assign rd_accept = req_valid && !req_write;

  generate
    for (genvar b = 0; b < NUM_SPACES; b++) begin : g_bank
      logic             bank_hit;
      logic [PID_W-1:0] pid;
      logic [RIS_W-1:0] ris;
      logic             internal;

      assign bank_hit = (req_space == 2'(b));

      capl_sel_reg #(
        .PID_W (PID_W),
        .RIS_W (RIS_W),
        .RIS_EN(RIS_EN)
      ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_hit && req_write && bank_hit),
        .wdata   (req_wdata),
        .pid     (pid),
        .ris     (ris),
        .internal(internal),
        .rd_word (sel_word[b])
      );

      if (FEAT_EN) begin : g_store
        logic [IDX_W-1:0]  idx;
        logic              entry_ok;
        logic [FRAC_W-1:0] rd_frac;

        capl_entry_decode #(
          .PID_W    (PID_W),
          .RIS_W    (RIS_W),
          .RIS_EN   (RIS_EN),
          .PID_MAX  (PID_MAX),
          .RIS_MAX  (RIS_MAX),
          .NARROW_EN(NARROW_EN),
          .IDX_W    (IDX_W)
        ) u_dec (
          .pid     (pid),
          .ris     (ris),
          .internal(internal),
          .idx     (idx),
          .hit     (entry_ok)
        );

        capl_frac_store #(
          .IDX_W (IDX_W),
          .FRAC_W(FRAC_W)
        ) u_store (
          .clk    (clk),
          .rst_n  (rst_n),
          .wr_en  (win_hit && req_write && bank_hit && entry_ok),
          .wr_idx (idx),
          .wr_frac(req_wdata[FRAC_FIELD_W-1 -: FRAC_W]),
          .rd_idx (idx),
          .rd_frac(rd_frac)
        );

        assign frac_word[b] = entry_ok ? (32'(rd_frac) << LOW_PAD) : 32'h0;
      end else begin : g_absent
        logic unused_sel;
        assign unused_sel   = ^{pid, ris, internal};
        assign frac_word[b] = 32'h0;
      end
    end
  endgenerate

  always_comb begin
    rd_mux = 32'h0;
    if (sel_hit)      rd_mux = sel_word[req_space];
    else if (win_hit) rd_mux = frac_word[req_space];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= rd_accept;
      rsp_rdata <= rd_accept ? rd_mux : 32'h0;
    end
  end
endmodule

// File: rtl/capl_chk.sv
module capl_chk #(
  parameter int ADDR_W   = 12,
  parameter int FRAC_W   = 8,
  parameter bit REALM_EN = 1'b1,
  parameter bit FEAT_EN  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_space,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata
);
  import capl_pkg::*;

  localparam logic [ADDR_W-1:0] A_SEL   = ADDR_W'(OFS_SELECT);
  localparam logic [ADDR_W-1:0] A_WIN   = ADDR_W'(OFS_WINDOW);
  localparam logic [31:0]       LOWMASK = 32'((1 << (FRAC_FIELD_W - FRAC_W)) - 1);

  p_read_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  p_write_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_addr) == A_WIN) |-> (rsp_rdata[31:16] == 16'h0));

  p_low_bits_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_addr) == A_WIN) |-> ((rsp_rdata & LOWMASK) == 32'h0));

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_addr) != A_WIN && $past(req_addr) != A_SEL)
      |-> (rsp_rdata == 32'h0));

  generate
    if (!REALM_EN) begin : g_realm_off
      p_space_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_space[1])) |-> (rsp_rdata == 32'h0));
    end
    if (!FEAT_EN) begin : g_feat_off
      p_feat_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_addr) == A_WIN) |-> (rsp_rdata == 32'h0));
    end
  endgenerate
endmodule

bind capl_bank_top capl_chk #(
  .ADDR_W  (ADDR_W),
  .FRAC_W  (FRAC_W),
  .REALM_EN(REALM_EN),
  .FEAT_EN (FEAT_EN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_space(req_space),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata)
);

// File: tb/sim_capl_bank_top.sv
`timescale 1ns/1ps
module sim_capl_bank_top;
  localparam int NI = 3;
  localparam int C_PIDW [NI] = '{4, 3, 4};
  localparam int C_PMAX [NI] = '{11, 5, 11};
  localparam int C_RISE [NI] = '{1, 0, 1};
  localparam int C_RISW [NI] = '{2, 2, 2};
  localparam int C_RMAX [NI] = '{2, 2, 2};
  localparam int C_FW   [NI] = '{8, 5, 8};
  localparam int C_NAR  [NI] = '{0, 1, 0};
  localparam int C_RLM  [NI] = '{1, 0, 1};
  localparam int C_FEAT [NI] = '{1, 1, 0};
  localparam logic [11:0] A_SEL = 12'h100;
  localparam logic [11:0] A_WIN = 12'h110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_space = '0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [NI-1:0] req_ready, rsp_valid;
  logic [31:0] rsp_rdata [NI];

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [31:0] m_sel  [NI][4];
  logic [15:0] m_frac [NI][4][64];

  always #2 clk = ~clk;

  capl_bank_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready[0]),
    .req_write(req_write), .req_space(req_space), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]));

  capl_bank_top #(.PID_W(3), .PID_MAX(5), .RIS_EN(1'b0), .FRAC_W(5),
                  .NARROW_EN(1'b1), .REALM_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready[1]),
    .req_write(req_write), .req_space(req_space), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]));

  capl_bank_top #(.FEAT_EN(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready[2]),
    .req_write(req_write), .req_space(req_space), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid[2]), .rsp_rdata(rsp_rdata[2]));

  task automatic chk(string tag, int inst, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s inst%0d actual=%h expected=%h", tag, inst, act, exp);
    end
  endtask

  function automatic logic [31:0] sel_mask(int i);
    logic [31:0] m;
    m = (32'd1 << C_PIDW[i]) - 1;
    m[16] = 1'b1;
    if (C_RISE[i] != 0) m |= ((32'd1 << C_RISW[i]) - 1) << 24;
    return m;
  endfunction

  function automatic bit space_ok(int i, int sp);
    return (sp < 2) || (C_RLM[i] != 0);
  endfunction

  function automatic int f_pid(int i, int sp);
    return int'(m_sel[i][sp] & ((32'd1 << C_PIDW[i]) - 1));
  endfunction

  function automatic int f_ris(int i, int sp);
    return int'((m_sel[i][sp] >> 24) & ((32'd1 << C_RISW[i]) - 1));
  endfunction

  function automatic bit entry_ok(int i, int sp);
    if (C_FEAT[i] == 0 || !space_ok(i, sp)) return 0;
    if (int'(m_sel[i][sp][16]) != C_NAR[i]) return 0;
    if (f_pid(i, sp) > C_PMAX[i]) return 0;
    if (C_RISE[i] != 0 && f_ris(i, sp) > C_RMAX[i]) return 0;
    return 1;
  endfunction

  function automatic int f_idx(int i, int sp);
    return (C_RISE[i] != 0) ? ((f_ris(i, sp) << C_PIDW[i]) | f_pid(i, sp)) : f_pid(i, sp);
  endfunction

  function automatic logic [15:0] fmask(int i);
    return 16'(((32'd1 << C_FW[i]) - 1) << (16 - C_FW[i]));
  endfunction

  function automatic logic [31:0] exp_read(int i, int sp, logic [11:0] a);
    if (!space_ok(i, sp)) return 32'h0;
    if (a == A_SEL) return m_sel[i][sp];
    if (a == A_WIN && entry_ok(i, sp)) return {16'h0, m_frac[i][sp][f_idx(i, sp)]};
    return 32'h0;
  endfunction

  function automatic void model_write(int sp, logic [11:0] a, logic [31:0] wd);
    for (int i = 0; i < NI; i++) begin
      if (space_ok(i, sp)) begin
        if (a == A_SEL) m_sel[i][sp] = wd & sel_mask(i);
        else if (a == A_WIN && entry_ok(i, sp))
          m_frac[i][sp][f_idx(i, sp)] = wd[15:0] & fmask(i);
      end
    end
  endfunction

  task automatic access(string tag, bit wr, int sp, logic [11:0] a, logic [31:0] wd);
    logic [31:0] exp [NI];
    for (int i = 0; i < NI; i++) exp[i] = exp_read(i, sp, a);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_space = 2'(sp);
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < NI; i++) begin
      chk("R2", i, {31'h0, rsp_valid[i]}, {31'h0, !wr});
      if (!wr) chk(tag, i, rsp_rdata[i], exp[i]);
    end
    if (wr) model_write(sp, a, wd);
  endtask

  function automatic logic [31:0] sel_val(int pid, bit intl, int ris);
    return 32'(pid) | (32'(intl) << 16) | (32'(ris) << 24);
  endfunction

  initial begin
    for (int i = 0; i < NI; i++)
      for (int s = 0; s < 4; s++) begin
        m_sel[i][s] = '0;
        for (int k = 0; k < 64; k++) m_frac[i][s][k] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      chk("R1", i, {31'h0, req_ready[i]}, 32'h1);
      chk("R1", i, {31'h0, rsp_valid[i]}, 32'h0);
    end
    for (int s = 0; s < 4; s++) begin
      access("R1", 0, s, A_SEL, 0);
      access("R1", 0, s, A_WIN, 0);
    end
    // R2: idle cycle leaves rsp_valid low
    @(negedge clk);
    for (int i = 0; i < NI; i++) chk("R2", i, {31'h0, rsp_valid[i]}, 32'h0);

    // R5: select layout and immediate effect
    access("R5", 1, 0, A_SEL, 32'hFFFF_FFFF);
    access("R5", 0, 0, A_SEL, 0);
    access("R5", 1, 0, A_SEL, sel_val(3, 0, 1));
    access("R5", 1, 0, A_WIN, 32'hFFFF_FFFF);
    access("R4", 0, 0, A_WIN, 0);
    access("R3", 1, 0, A_WIN, 32'hABCD_5A3C);
    access("R3", 0, 0, A_WIN, 0);
    // R6: other bank same index, secure unchanged
    access("R6", 1, 1, A_SEL, sel_val(3, 0, 1));
    access("R6", 1, 1, A_WIN, 32'h0000_1200);
    access("R6", 0, 0, A_WIN, 0);
    access("R6", 0, 1, A_WIN, 0);
    // R7: resource index selects a different entry (u0) or aliases (u1)
    access("R7", 1, 0, A_SEL, sel_val(3, 0, 2));
    access("R7", 1, 0, A_WIN, 32'h0000_7700);
    access("R7", 1, 0, A_SEL, sel_val(3, 0, 1));
    access("R7", 0, 0, A_WIN, 0);
    // R8: internal flag set
    access("R8", 1, 0, A_SEL, sel_val(2, 1, 0));
    access("R8", 1, 0, A_WIN, 32'h0000_C800);
    access("R8", 0, 0, A_WIN, 0);
    access("R8", 1, 0, A_SEL, sel_val(2, 0, 0));
    access("R8", 0, 0, A_WIN, 0);
    // R9: partition and resource limits
    access("R9", 1, 0, A_SEL, sel_val(12, 0, 0));
    access("R9", 1, 0, A_WIN, 32'h0000_FF00);
    access("R9", 0, 0, A_WIN, 0);
    access("R9", 1, 0, A_SEL, sel_val(1, 0, 3));
    access("R9", 1, 0, A_WIN, 32'h0000_FF00);
    access("R9", 0, 0, A_WIN, 0);
    access("R9", 1, 0, A_SEL, sel_val(1, 0, 0));
    access("R9", 0, 0, A_WIN, 0);
    // R10: root and realm spaces
    for (int s = 2; s < 4; s++) begin
      access("R10", 1, s, A_SEL, sel_val(4, 1, 0));
      access("R10", 1, s, A_WIN, 32'h0000_9900);
      access("R10", 0, s, A_SEL, 0);
      access("R10", 0, s, A_WIN, 0);
    end
    // R11: feature absent instance
    access("R11", 1, 1, A_SEL, sel_val(5, 0, 0));
    access("R11", 1, 1, A_WIN, 32'h0000_F000);
    access("R11", 0, 1, A_WIN, 0);
    // R12: unmapped offsets
    access("R12", 1, 0, 12'h114, 32'hFFFF_FFFF);
    access("R12", 1, 0, 12'h000, 32'hFFFF_FFFF);
    access("R12", 0, 0, 12'h104, 0);
    access("R12", 0, 0, A_WIN, 0);
    access("R12", 0, 0, A_SEL, 0);

    // Random phase (R3 tags window data)
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 3000; n++) begin
      int sp;
      int pick;
      logic [11:0] a;
      logic [31:0] wd;
      sp = int'($urandom_range(0, 3));
      pick = int'($urandom_range(0, 7));
      a = (pick < 3) ? A_SEL : (pick < 7) ? A_WIN : 12'h108;
      if (a == A_SEL)
        wd = sel_val(int'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0),
                     int'($urandom_range(0, 3))) | ($urandom & 32'hF0FE_FF00);
      else
        wd = $urandom;
      access("R3", $urandom_range(0, 1) == 1, sp, a, wd);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule